// File: doc/BRIEF.md
# Fetch Address Watchpoint Unit

This unit watches the instruction fetch stream and flags the fetches that hit programmed address criteria. It has four watch slots organised as two pairs, (1,2) and (3,4). Each slot holds an address register. Each pair has a mode that picks one of two setups. In the first, each slot does its own exact compare. In the second, the pair's two registers form one comparator: a masked compare, a window, or the complement of a window. In that second setup only the first slot of the pair reports.

Each slot can also require a privilege state and an instruction-space bit before it reports. Both qualifiers include an encoding that never matches. Software loads a 32-bit control word and the four address registers through a single-cycle write port. The unit drives four registered event flags, one per slot, for a downstream debug controller.

Top module: `fetch_watch`

## Requirements
- R1: Pair mode 00 (exact): the first slot flags a fetch whose address equals its own register, and the second slot does the same with its own register. The two slots are independent.
- R2: Pair mode 01 (masked): the first slot flags a fetch when (address AND second register) equals (first register AND second register).
- R3: Pair mode 10 (window): the first slot flags a fetch whose address is at least the first register and strictly below the second register. The compare is unsigned.
- R4: Pair mode 11 (outside window): the first slot flags a fetch whose address is strictly below the first register, or at least the second register. The compare is unsigned.
- R5: In pair modes 01, 10 and 11 the second slot of the pair never flags. The first slot's qualifiers alone gate the combined match.
- R6: The 2-bit privilege qualifier works as follows. 00 ignores privilege. 01 never matches. 10 matches only when `fetch_pr`=0 (supervisor). 11 matches only when `fetch_pr`=1 (user).
- R7: The 2-bit space qualifier works as follows. 00 has no restriction. 01 never matches. 10 needs `fetch_is`=0. 11 needs `fetch_is`=1.
- R8: A fetch presented with `fetch_valid`=1 at a rising edge sets the flags on that edge. The flags last exactly one cycle unless another matching fetch follows. No flag is set after a cycle with `fetch_valid`=0. `evt[k]` belongs to slot k+1.
- R9: A write takes effect at the edge where it is captured. A fetch sampled on that same edge uses the old register values.
- R10: `wr_sel` selects the target of a write. 0 is the control word and 1 to 4 are the address registers of slots 1 to 4. Codes 5 to 7 are ignored. The control word uses big-endian numbering, so bit 0 is `wr_data[31]`. The fields are: slot1 privilege 0:1, slot1 space 2:3, slot2 privilege 4:5, slot2 space 6:7, pair(1,2) mode 8:9, slot3 privilege 16:17, slot3 space 18:19, slot4 privilege 20:21, slot4 space 22:23, pair(3,4) mode 24:25. The first bit of each field is its MSB.
- R11: After reset the flags are 0. The control word and all address registers are 0, so a valid fetch of address 0 flags all four slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_pr | input | 1 | Privilege state, 1 = user |
| fetch_is | input | 1 | Instruction-space bit |
| evt | output | 4 | Registered per-slot event flags |

## Verification
Each mode is driven with addresses at and on either side of its boundaries: the lower register, the value one below it, the upper register and the value one below that. This separates a `>=` compare from a `>` compare and an inclusive bound from an exclusive one. In the masked mode, addresses that differ only in don't-care bits are contrasted with addresses that differ in a care bit. Every qualifier encoding is paired with both values of the privilege and space inputs. This exposes swapped polarities and a never-match encoding that leaks through. A write issued in the same cycle as a fetch, followed by a repeat of that fetch, separates old-value use from write-through. A slot 4 qualifier set to never-match while pair (3,4) is in window mode shows that only slot 3's qualifiers gate the fused match.

// File: rtl/fetch_watch_pkg.sv
package fetch_watch_pkg;
  typedef enum logic [1:0] {
    PM_EXACT   = 2'b00,
    PM_MASK    = 2'b01,
    PM_INSIDE  = 2'b10,
    PM_OUTSIDE = 2'b11
  } pair_mode_e;

  typedef struct packed {
    logic [1:0] priv;
    logic [1:0] space;
  } slot_qual_t;

  localparam int CTRL_W   = 32;
  localparam int SEL_W    = 3;
  localparam int FIELD_PW = 16;
endpackage

// File: rtl/fw_qualifier.sv
module fw_qualifier
  import fetch_watch_pkg::*;
(
  input  slot_qual_t qual,
  input  logic       fetch_pr,
  input  logic       fetch_is,
  output logic       ok
);
  logic priv_ok;
  logic space_ok;

  always_comb begin
    unique case (qual.priv)
      2'b00:   priv_ok = 1'b1;
      2'b10:   priv_ok = !fetch_pr;
      2'b11:   priv_ok = fetch_pr;
      default: priv_ok = 1'b0;
    endcase
    unique case (qual.space)
      2'b00:   space_ok = 1'b1;
      2'b10:   space_ok = !fetch_is;
      2'b11:   space_ok = fetch_is;
      default: space_ok = 1'b0;
    endcase
    ok = priv_ok && space_ok;
  end
endmodule

// File: rtl/fw_pair.sv
module fw_pair
  import fetch_watch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  pair_mode_e        mode,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_valid,
  input  logic              qual_a_ok,
  input  logic              qual_b_ok,
  output logic              hit_a,
  output logic              hit_b
);
  logic eq_a;
  logic eq_b;
  logic ge_a;
  logic lt_b;
  logic mask_eq;
  logic cmp_a;

  always_comb begin
    eq_a    = (fetch_addr == addr_a);
    eq_b    = (fetch_addr == addr_b);
    ge_a    = (fetch_addr >= addr_a);
    lt_b    = (fetch_addr < addr_b);
    mask_eq = ((fetch_addr & addr_b) == (addr_a & addr_b));
    unique case (mode)
      PM_EXACT:   cmp_a = eq_a;
      PM_MASK:    cmp_a = mask_eq;
      PM_INSIDE:  cmp_a = ge_a && lt_b;
      PM_OUTSIDE: cmp_a = !ge_a || !lt_b;
      default:    cmp_a = 1'b0;
    endcase
    hit_a = fetch_valid && qual_a_ok && cmp_a;
    hit_b = fetch_valid && qual_b_ok && (mode == PM_EXACT) && eq_b;
  end
endmodule

// File: rtl/fetch_watch.sv
module fetch_watch
  import fetch_watch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic                fetch_valid,
  input  logic [ADDR_W-1:0]   fetch_addr,
  input  logic                fetch_pr,
  input  logic                fetch_is,
  output logic [3:0]          evt
);
  localparam int NUM_PAIRS = 2;
  localparam int NUM_SLOTS = 2 * NUM_PAIRS;

  logic rst_meta_n;
  logic rst_sync_n;
  logic ctrl_we;
  logic [NUM_SLOTS-1:0] addr_we;
  logic [NUM_SLOTS-1:0] evt_d;
  logic [NUM_SLOTS-1:0] evt_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    ctrl_we = wr_en && (wr_sel == SEL_W'(0));
    for (int s = 0; s < NUM_SLOTS; s++) begin
      addr_we[s] = wr_en && (wr_sel == SEL_W'(s + 1));
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    // field block of pair p sits at little-endian offset BASE
    localparam int BASE = CTRL_W - FIELD_PW * (p + 1);

    pair_mode_e        mode_q, mode_d;
    slot_qual_t        qa_q, qa_d, qb_q, qb_d;
    logic [ADDR_W-1:0] aa_q, aa_d, ab_q, ab_d;
    logic              pair_we;
    logic              ok_a, ok_b;
    logic              hit_a, hit_b;

    always_comb begin
      pair_we = ctrl_we || addr_we[2*p] || addr_we[2*p+1];
      mode_d  = mode_q;
      qa_d    = qa_q;
      qb_d    = qb_q;
      aa_d    = aa_q;
      ab_d    = ab_q;
      if (ctrl_we) begin
        mode_d     = pair_mode_e'(wr_data[BASE+7:BASE+6]);
        qa_d.priv  = wr_data[BASE+15:BASE+14];
        qa_d.space = wr_data[BASE+13:BASE+12];
        qb_d.priv  = wr_data[BASE+11:BASE+10];
        qb_d.space = wr_data[BASE+9:BASE+8];
      end
      if (addr_we[2*p])   aa_d = wr_data[ADDR_W-1:0];
      if (addr_we[2*p+1]) ab_d = wr_data[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        mode_q <= PM_EXACT;
        qa_q   <= '0;
        qb_q   <= '0;
        aa_q   <= '0;
        ab_q   <= '0;
      end else if (pair_we) begin
        mode_q <= mode_d;
        qa_q   <= qa_d;
        qb_q   <= qb_d;
        aa_q   <= aa_d;
        ab_q   <= ab_d;
      end
    end

    fw_qualifier u_qual_a (
      .qual(qa_q), .fetch_pr(fetch_pr), .fetch_is(fetch_is), .ok(ok_a)
    );
    fw_qualifier u_qual_b (
      .qual(qb_q), .fetch_pr(fetch_pr), .fetch_is(fetch_is), .ok(ok_b)
    );

    fw_pair #(.ADDR_W(ADDR_W)) u_cmp (
      .mode(mode_q), .addr_a(aa_q), .addr_b(ab_q),
      .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
      .qual_a_ok(ok_a), .qual_b_ok(ok_b),
      .hit_a(hit_a), .hit_b(hit_b)
    );

    assign evt_d[2*p]   = hit_a;
    assign evt_d[2*p+1] = hit_b;

    AST_SECOND_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ($past(mode_q) != PM_EXACT) |-> !evt_q[2*p+1]) else $error("second slot fired"); // R5
    AST_PRIV_NEVER: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ($past(qa_q.priv) == 2'b01) |-> !evt_q[2*p]) else $error("reserved privilege matched"); // R6
    AST_PRIV_SUPER: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (($past(qa_q.priv) == 2'b10) && $past(fetch_pr)) |-> !evt_q[2*p]) else $error("user fetch passed supervisor gate"); // R6
    AST_SPACE_NEVER: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (($past(qa_q.space) == 2'b01) || ($past(qb_q.space) == 2'b01)) |->
      !(evt_q[2*p] && ($past(qa_q.space) == 2'b01)) && !(evt_q[2*p+1] && ($past(qb_q.space) == 2'b01)))
      else $error("real-address slot matched"); // R7
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) evt_q <= '0;
    else             evt_q <= evt_d;
  end

  assign evt = evt_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(fetch_valid) |-> (evt_q == '0)) else $error("flag without fetch"); // R8
endmodule

// File: tb/fetch_watch_bench.sv
module fetch_watch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        fetch_pr;
  logic        fetch_is;
  logic [3:0]  evt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fetch_watch u_fetch_watch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_pr(fetch_pr),
    .fetch_is(fetch_is), .evt(evt)
  );

  task automatic check(input string tag, input [3:0] got, input [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: evt=%b expected=%b", tag, got, exp);
    end
  endtask

  // place a 2-bit field whose big-endian MSB position is be_msb
  function automatic [31:0] fld(input [31:0] w, input int be_msb, input [1:0] v);
    w[31-be_msb] = v[1];
    w[30-be_msb] = v[0];
    return w;
  endfunction

  function automatic [31:0] mk_ctrl(input [1:0] m12, input [1:0] m34,
      input [1:0] p1, input [1:0] s1, input [1:0] p2, input [1:0] s2,
      input [1:0] p3, input [1:0] s3, input [1:0] p4, input [1:0] s4);
    logic [31:0] w = '0;
    w = fld(w, 0, p1);  w = fld(w, 2, s1);
    w = fld(w, 4, p2);  w = fld(w, 6, s2);
    w = fld(w, 8, m12);
    w = fld(w, 16, p3); w = fld(w, 18, s3);
    w = fld(w, 20, p4); w = fld(w, 22, s4);
    w = fld(w, 24, m34);
    return w;
  endfunction

  task automatic wr(input [2:0] sel, input [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fetch(input [31:0] a, input pr, input is, input [3:0] exp, input string tag);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_pr = pr; fetch_is = is;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(tag, evt, exp);
  endtask

  task automatic t_reset;
    check("R11 flags after reset", evt, 4'b0000);
    fetch(32'h0, 1'b0, 1'b0, 4'b1111, "R11 defaults match address 0");
  endtask

  task automatic t_exact;
    wr(3'd0, mk_ctrl(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h0000_2000);
    wr(3'd3, 32'h0000_3000);
    wr(3'd4, 32'h0000_4000);
    fetch(32'h0000_1000, 0, 0, 4'b0001, "R1 slot1 exact");
    fetch(32'h0000_2000, 0, 0, 4'b0010, "R1 slot2 exact");
    fetch(32'h0000_4000, 0, 0, 4'b1000, "R1 slot4 exact");
    fetch(32'h0000_1004, 0, 0, 4'b0000, "R1 near miss");
  endtask

  task automatic t_mask;
    wr(3'd0, mk_ctrl(2'b01, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3'd1, 32'h0000_1200);
    wr(3'd2, 32'hFFFF_FF00);
    fetch(32'h0000_12FC, 0, 0, 4'b0001, "R2 don't-care bits differ");
    fetch(32'h0000_1300, 0, 0, 4'b0000, "R2 care bit differs");
    fetch(32'hFFFF_FF00, 0, 0, 4'b0000, "R5 slot2 silent in mask mode");
  endtask

  task automatic t_inside;
    wr(3'd0, mk_ctrl(2'b00, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3'd3, 32'h0000_0100);
    wr(3'd4, 32'h0000_0200);
    fetch(32'h0000_0100, 0, 0, 4'b0100, "R3 lower bound inclusive");
    fetch(32'h0000_01FF, 0, 0, 4'b0100, "R3 just below upper");
    fetch(32'h0000_0200, 0, 0, 4'b0000, "R3 upper bound excluded, R5 slot4 silent");
    fetch(32'h0000_00FF, 0, 0, 4'b0000, "R3 just below lower");
  endtask

  task automatic t_outside;
    wr(3'd0, mk_ctrl(2'b00, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0));
    fetch(32'h0000_00FF, 0, 0, 4'b0100, "R4 below lower");
    fetch(32'h0000_0100, 0, 0, 4'b0000, "R4 at lower");
    fetch(32'h0000_01FF, 0, 0, 4'b0000, "R4 below upper");
    fetch(32'h0000_0200, 0, 0, 4'b0100, "R4 at upper");
    fetch(32'hFFFF_FFFF, 0, 0, 4'b0100, "R4 unsigned top");
  endtask

  task automatic t_fused_qual;
    // slot4 space never-match must not block slot3 in window mode
    wr(3'd0, mk_ctrl(2'b00, 2'b10, 0, 0, 0, 0, 0, 0, 0, 2'b01));
    fetch(32'h0000_0150, 0, 0, 4'b0100, "R5 slot3 qualifiers govern");
    wr(3'd0, mk_ctrl(2'b00, 2'b10, 0, 0, 0, 0, 2'b11, 0, 0, 0));
    fetch(32'h0000_0150, 0, 0, 4'b0000, "R5 slot3 user-only, supervisor fetch");
    fetch(32'h0000_0150, 1, 0, 4'b0100, "R5 slot3 user-only, user fetch");
  endtask

  task automatic t_priv;
    wr(3'd1, 32'h0000_0040);
    wr(3'd2, 32'h0000_0040);
    wr(3'd0, mk_ctrl(2'b00, 2'b00, 2'b10, 0, 2'b11, 0, 0, 0, 0, 0));
    fetch(32'h0000_0040, 0, 0, 4'b0001, "R6 supervisor fetch");
    fetch(32'h0000_0040, 1, 0, 4'b0010, "R6 user fetch");
    wr(3'd0, mk_ctrl(2'b00, 2'b00, 2'b01, 0, 2'b00, 0, 0, 0, 0, 0));
    fetch(32'h0000_0040, 0, 0, 4'b0010, "R6 reserved never, pr=0");
    fetch(32'h0000_0040, 1, 0, 4'b0010, "R6 reserved never, pr=1");
  endtask

  task automatic t_space;
    wr(3'd0, mk_ctrl(2'b00, 2'b00, 0, 2'b10, 0, 2'b11, 0, 0, 0, 0));
    fetch(32'h0000_0040, 0, 0, 4'b0001, "R7 space bit 0");
    fetch(32'h0000_0040, 0, 1, 4'b0010, "R7 space bit 1");
    wr(3'd0, mk_ctrl(2'b00, 2'b00, 0, 2'b01, 0, 2'b00, 0, 0, 0, 0));
    fetch(32'h0000_0040, 0, 0, 4'b0010, "R7 real-address never, is=0");
    fetch(32'h0000_0040, 0, 1, 4'b0010, "R7 real-address never, is=1");
  endtask

  task automatic t_timing;
    wr(3'd0, mk_ctrl(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3'd2, 32'h0000_9000);
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = 32'h0000_0040;
    @(negedge clk);
    check("R8 no flag when fetch_valid low", evt, 4'b0000);
    fetch_valid = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
    check("R8 flag one cycle after fetch", evt, 4'b0001);
    @(negedge clk);
    check("R8 flag lasts one cycle", evt, 4'b0000);
  endtask

  task automatic t_write_order;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h0000_0080;
    fetch_valid = 1'b1; fetch_addr = 32'h0000_0040; fetch_pr = 0; fetch_is = 0;
    @(negedge clk);
    wr_en = 1'b0; fetch_valid = 1'b0;
    check("R9 same-cycle fetch sees old value", evt, 4'b0001);
    fetch(32'h0000_0040, 0, 0, 4'b0000, "R9 old value gone");
    fetch(32'h0000_0080, 0, 0, 4'b0001, "R9 new value active");
  endtask

  task automatic t_sel;
    wr(3'd5, 32'h0000_0040);
    wr(3'd7, 32'hFFFF_FFFF);
    fetch(32'h0000_0080, 0, 0, 4'b0001, "R10 unused selects ignored");
    wr(3'd0, 32'h0000_0040); // big-endian bit 25 only: pair(3,4) mode 01
    wr(3'd3, 32'h0000_0000);
    wr(3'd4, 32'h0000_000F);
    fetch(32'h0000_0F00, 0, 0, 4'b0100, "R10 pair(3,4) mode field position");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    fetch_valid = 1'b0; fetch_addr = '0; fetch_pr = 1'b0; fetch_is = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_exact();
    t_mask();
    t_inside();
    t_outside();
    t_fused_qual();
    t_priv();
    t_space();
    t_timing();
    t_write_order();
    t_sel();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule